// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent virtual-to-physical page translations and answers lookups from them in the same cycle. Each slot stores a virtual page tag, a physical page base, a page-size code, a permission field and a valid bit. Slots of every page size live in one array. The number of virtual-address bits that take part in a match depends on the page size stored in that slot.

A lookup that finds no matching slot raises a walk request. The external table walker later returns the translation on the fill port, and the block writes it into a slot. While free slots remain, the lowest-numbered free slot is used. Once every slot is valid, a cyclic victim pointer picks the slot. A lock base index protects the slots below it. The pointer never selects them and the invalidate-all input never clears them, so translations for critical regions stay resident. When translation is switched off, the virtual address passes through unchanged.

Top module: `tlb_lookup`

## Requirements
- R1: After reset no slot is valid: a lookup with translation enabled gives hit=0 and walk_req=1.
- R2: On a hit, in the same cycle, hit=1, walk_req=0, perm equals the slot's permission field, and pa takes its page-number bits from the slot's physical base and its offset bits from lk_va.
- R3: With translation enabled and lk_valid=1, a lookup that matches no valid slot gives hit=0 and walk_req=1. A fill accepted on a clock edge can be looked up from the next cycle onward.
- R4: Page size code in fill_size: 0 = 1 MB (va[31:20] compared), 1 = 64 KB (va[31:16]), 2 = 4 KB (va[31:12]), 3 = 1 KB (va[31:10]). The bits below the compared range form the offset.
- R5: While any slot is invalid, a fill goes to the lowest-numbered invalid slot.
- R6: While all slots are valid, a fill goes to the slot named by the victim pointer. The pointer is 0 after reset and advances by one after every accepted fill. It wraps from the last slot to lock_base, and any value below lock_base is treated as lock_base.
- R7: Slots with an index below lock_base are never chosen as replacement victims.
- R8: inval_all clears the valid bit of every slot at or above lock_base in one cycle and keeps the slots below it. A fill in the same cycle is dropped and does not move the pointer.
- R9: With xlate_en=0, pa equals lk_va, and hit and walk_req are 0, whatever the slots hold.
- R10: When more than one valid slot matches an address, the lowest-numbered slot supplies pa and perm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation enable; 0 passes addresses through |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_va | input | 32 | Virtual address to translate |
| hit | output | 1 | A valid slot matched |
| pa | output | 32 | Translated (or passed-through) address |
| perm | output | PERM_W | Permission field of the matching slot, 0 on no hit |
| walk_req | output | 1 | Request a table walk for lk_va |
| fill_valid | input | 1 | Write a returned translation this cycle |
| fill_va | input | 32 | Virtual address of the returned translation |
| fill_pa | input | 32 | Physical address of the returned translation |
| fill_size | input | 2 | Page size code of the returned translation |
| fill_perm | input | PERM_W | Permission field of the returned translation |
| lock_base | input | IDX_W | Slots below this index are locked |
| inval_all | input | 1 | Clear all unlocked slots |

## Verification
The assertions assume that inval_all and fill_valid are both 0 during reset, that lock_base only changes in cycles without a fill, and that the walker never returns a translation whose range lies entirely inside one already held. The bench drives every input on the falling edge and keeps fill and invalidate low across reset. It changes lock_base only between operations and draws fill addresses from distinct, non-overlapping pages. The one exception is the priority test, which adds overlaps on purpose: pages of different sizes that share addresses.

// File: rtl/tlb_lookup.sv
module tlb_lookup #(
  parameter int ENTRIES = 64,
  parameter int PERM_W = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlate_en,
  input  logic              lk_valid,
  input  logic [31:0]       lk_va,
  output logic              hit,
  output logic [31:0]       pa,
  output logic [PERM_W-1:0] perm,
  output logic              walk_req,
  input  logic              fill_valid,
  input  logic [31:0]       fill_va,
  input  logic [31:0]       fill_pa,
  input  logic [1:0]        fill_size,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic [IDX_W-1:0]  lock_base,
  input  logic              inval_all
);

  localparam int PG_W = 22;

  function automatic logic [PG_W-1:0] size_mask(input logic [1:0] s);
    case (s)
      2'd0:    return 22'h3FFC00;
      2'd1:    return 22'h3FFFC0;
      2'd2:    return 22'h3FFFFC;
      default: return 22'h3FFFFF;
    endcase
  endfunction

  logic [PG_W-1:0]   tag_q   [ENTRIES];
  logic [PG_W-1:0]   pbase_q [ENTRIES];
  logic [1:0]        size_q  [ENTRIES];
  logic [PERM_W-1:0] perm_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [IDX_W-1:0]   ptr_q;

  logic [ENTRIES-1:0] match, locked_mask;
  logic               any_match, any_free;
  logic [IDX_W-1:0]   hit_idx, free_idx, ptr_eff, ptr_nxt, victim;
  logic [PG_W-1:0]    hit_mask;
  logic               accept;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign match[i] = valid_q[i] &&
                      (((tag_q[i] ^ lk_va[31:10]) & size_mask(size_q[i])) == '0);
    assign locked_mask[i] = (IDX_W'(i) < lock_base);
  end

  always_comb begin
    any_match = 1'b0;
    hit_idx   = '0;
    any_free  = 1'b0;
    free_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        any_match = 1'b1;
        hit_idx   = IDX_W'(i);
      end
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign hit_mask = size_mask(size_q[hit_idx]);
  assign hit      = xlate_en && lk_valid && any_match;
  assign walk_req = xlate_en && lk_valid && !any_match;
  assign perm     = hit ? perm_q[hit_idx] : '0;
  assign pa       = !xlate_en ? lk_va :
                    {(pbase_q[hit_idx] & hit_mask) | (lk_va[31:10] & ~hit_mask), lk_va[9:0]};

  assign ptr_eff = (ptr_q < lock_base) ? lock_base : ptr_q;
  assign ptr_nxt = (ptr_eff == IDX_W'(ENTRIES - 1)) ? lock_base : ptr_eff + 1'b1;
  assign victim  = any_free ? free_idx : ptr_eff;
  assign accept  = fill_valid && !inval_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (inval_all) begin
      valid_q <= valid_q & locked_mask;
    end else if (fill_valid) begin
      valid_q[victim] <= 1'b1;
      ptr_q           <= ptr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      tag_q[victim]   <= fill_va[31:10];
      pbase_q[victim] <= fill_pa[31:10];
      size_q[victim]  <= fill_size;
      perm_q[victim]  <= fill_perm;
    end
  end

  assert_walk_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !hit);

  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_en |-> (pa == lk_va && !hit && !walk_req));

  assert_fill_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> valid_q[$past(victim)]);

  assert_victim_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !any_free) |-> !locked_mask[victim]);

  assert_inval_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> ((valid_q & ~$past(locked_mask)) == '0));

  assert_inval_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> ((valid_q & $past(locked_mask)) == ($past(valid_q) & $past(locked_mask))));

  assert_count_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !inval_all |=> ($countones(valid_q) >= $past($countones(valid_q))));

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(ptr_q));

endmodule

// File: tb/tlb_lookup_bench.sv
`timescale 1ns/1ps
module tlb_lookup_bench;
  localparam int N = 64;

  logic clk = 0, rst_n = 0, xlate_en = 0, lk_valid = 0, fill_valid = 0, inval_all = 0;
  logic [31:0] lk_va = 0, fill_va = 0, fill_pa = 0;
  logic [1:0] fill_size = 0;
  logic [3:0] fill_perm = 0;
  logic [5:0] lock_base = 0;
  logic hit, walk_req;
  logic [31:0] pa;
  logic [3:0] perm;

  tlb_lookup u_tlb_lookup (.clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .lk_valid(lk_valid),
    .lk_va(lk_va), .hit(hit), .pa(pa), .perm(perm), .walk_req(walk_req), .fill_valid(fill_valid),
    .fill_va(fill_va), .fill_pa(fill_pa), .fill_size(fill_size), .fill_perm(fill_perm),
    .lock_base(lock_base), .inval_all(inval_all));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit m_valid [N];
  logic [31:0] m_va [N], m_pa [N];
  logic [1:0] m_size [N];
  logic [3:0] m_perm [N];
  int m_ptr = 0;
  int lb = 0;
  int gen = 0;
  logic [31:0] evicted [$];

  function automatic logic [31:0] pmask(input logic [1:0] s);
    case (s)
      2'd0: return 32'hFFF0_0000;
      2'd1: return 32'hFFFF_0000;
      2'd2: return 32'hFFFF_F000;
      default: return 32'hFFFF_FC00;
    endcase
  endfunction

  function automatic int m_find(input logic [31:0] va);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && ((va & pmask(m_size[i])) == (m_va[i] & pmask(m_size[i])))) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input string tag, input logic [31:0] va);
    int k;
    logic [31:0] epa;
    @(negedge clk);
    xlate_en = 1; lk_valid = 1; lk_va = va;
    #1;
    k = m_find(va);
    epa = (k < 0) ? 32'bx : ((m_pa[k] & pmask(m_size[k])) | (va & ~pmask(m_size[k])));
    chk({tag, " hit"}, {31'd0, hit}, {31'd0, k >= 0});
    chk({tag, " walk"}, {31'd0, walk_req}, {31'd0, k < 0});
    if (k >= 0) begin
      chk({tag, " pa"}, pa, epa);
      chk({tag, " perm"}, {28'd0, perm}, {28'd0, m_perm[k]});
    end
    lk_valid = 0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] fpa, input logic [1:0] sz,
                      input logic [3:0] pm);
    int v = -1;
    int pe;
    @(negedge clk);
    fill_valid = 1; fill_va = va; fill_pa = fpa; fill_size = sz; fill_perm = pm;
    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) v = i;
    pe = (m_ptr < lb) ? lb : m_ptr;
    if (v < 0) begin
      v = pe;
      evicted.push_back(m_va[v]);
    end
    m_ptr = (pe == N - 1) ? lb : pe + 1;
    m_valid[v] = 1; m_va[v] = va; m_pa[v] = fpa; m_size[v] = sz; m_perm[v] = pm;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic fill_gen();
    fill(32'h5000_0000 + gen * 32'h1000, 32'h6000_0000 + gen * 32'h2000, 2'd2, 4'(gen));
    gen++;
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < N; i++) if (m_valid[i]) look(tag, m_va[i] | 32'h0000_0004);
    while (evicted.size() > 0) begin
      logic [31:0] e;
      e = evicted.pop_front();
      if (m_find(e) < 0) look({tag, " evicted"}, e);
    end
  endtask

  task automatic test_reset_R1();
    look("R1 reset miss", 32'h1234_5678);
    look("R1 reset miss2", 32'h0000_0000);
  endtask

  task automatic test_bypass_R9(input string tag);
    @(negedge clk);
    xlate_en = 0; lk_valid = 1; lk_va = 32'h1230_0044;
    #1;
    chk({tag, " pa"}, pa, 32'h1230_0044);
    chk({tag, " hit"}, {31'd0, hit}, 32'd0);
    chk({tag, " walk"}, {31'd0, walk_req}, 32'd0);
    lk_valid = 0; xlate_en = 1;
  endtask

  task automatic test_sizes_R4();
    fill(32'h1230_0000, 32'hA560_0000, 2'd0, 4'd1);
    look("R3 fill then hit", 32'h1230_0000);
    fill(32'h2001_0000, 32'hB002_0000, 2'd1, 4'd2);
    fill(32'h3000_5000, 32'hC000_9000, 2'd2, 4'd3);
    fill(32'h4000_0C00, 32'hD000_0400, 2'd3, 4'd4);
    look("R2 R4 section", 32'h123A_BCDE);
    chk("R2 section pa fixed", pa, 32'hA56A_BCDE);
    look("R4 large", 32'h2001_FFFC);
    chk("R2 large pa fixed", pa, 32'hB002_FFFC);
    look("R4 small", 32'h3000_5ABC);
    look("R4 tiny", 32'h4000_0FFF);
    chk("R2 tiny pa fixed", pa, 32'hD000_07FF);
    look("R4 section miss", 32'h1240_0000);
    look("R4 large miss", 32'h2002_0000);
    look("R4 small miss", 32'h3000_6000);
    look("R4 tiny miss", 32'h4000_1000);
    look("R3 miss", 32'h7777_0000);
  endtask

  task automatic test_priority_R10();
    fill(32'h1230_1000, 32'hF000_1000, 2'd2, 4'd9);
    fill(32'h3000_0000, 32'hE000_0000, 2'd0, 4'd7);
    look("R10 low section wins", 32'h1230_1010);
    chk("R10 low section pa", pa, 32'hA560_1010);
    look("R10 low small wins", 32'h3000_5004);
    chk("R10 low small pa", pa, 32'hC000_9004);
    look("R10 section other", 32'h3000_7000);
    chk("R10 section other pa", pa, 32'hE000_7000);
  endtask

  task automatic test_fill_full_R5();
    while (m_find(32'h0) === -1 && !m_valid[N-1]) fill_gen();
    sweep("R5 full");
  endtask

  task automatic test_replace_R6();
    for (int i = 0; i < 10; i++) fill_gen();
    sweep("R6 cyclic");
  endtask

  task automatic test_lock_R7_R8();
    @(negedge clk);
    lock_base = 6'd4; lb = 4;
    inval_all = 1;
    for (int i = 4; i < N; i++) begin
      if (m_valid[i]) evicted.push_back(m_va[i]);
      m_valid[i] = 0;
    end
    @(negedge clk);
    inval_all = 0;
    sweep("R8 inval keeps locked");
    for (int i = 0; i < 130; i++) fill_gen();
    sweep("R7 locked survive");
    for (int i = 0; i < 4; i++) chk("R7 locked slot valid", {31'd0, m_valid[i]}, 32'd1);
  endtask

  task automatic test_inval_fill_R8();
    @(negedge clk);
    inval_all = 1; fill_valid = 1; fill_va = 32'h7F00_0000; fill_pa = 32'h0100_0000;
    fill_size = 2'd2; fill_perm = 4'd5;
    for (int i = 4; i < N; i++) m_valid[i] = 0;
    @(negedge clk);
    inval_all = 0; fill_valid = 0;
    look("R8 dropped fill", 32'h7F00_0000);
    fill_gen();
    sweep("R8 after drop");
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < N; i++) m_valid[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset_R1();
    test_bypass_R9("R9 empty");
    test_sizes_R4();
    test_priority_R10();
    test_bypass_R9("R9 with slots");
    test_fill_full_R5();
    test_replace_R6();
    test_lock_R7_R8();
    test_inval_fill_R8();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule